// File: doc/BRIEF.md
# Fractional-Edge Two-Channel PWM

This block is one pulse-width submodule with two independent outputs, A and B. A signed counter runs from a start value up to a period value, then reloads the start value. Each output has a rise compare and a fall compare. When the counter reaches the rise compare the output goes high, and when it reaches the fall compare the output goes low.

Each edge also has a 16-bit fractional word. Its top five bits give a fine-delay code in steps of 1/32 of a counter clock. The code appears on a per-channel fine output in the same cycle as the coarse edge it belongs to, so an external delay line can move that edge by the matching fraction. A global enable forces every fine code to zero, which leaves all edges at whole-clock positions.

The period, the compares, the fractional words and the enable are all captured into shadow copies at counter reload. A value changed in mid-period therefore cannot cut short or stretch the pulse that is running.

Top module: `fracEdgePwm`

## Requirements
- R1: After a reload the counter output shows the start value, then rises by one each clock, wrapping as a 16-bit two's-complement number. In the cycle it equals the shadowed period value, the next clock loads the start value again.
- R2: Output A goes high one clock after the cycle in which the counter equals the A rise compare. It goes low one clock after the cycle in which the counter equals the A fall compare. Otherwise it holds.
- R3: Output B follows the same rule as output A, using the B rise and B fall compares only. Its behaviour does not depend on A's settings.
- R4: In the clock where a compare match updates an output, that channel's fine output carries bits [15:11] of the fractional word for that edge. In every other clock the fine output is 0.
- R5: While the shadowed fractional enable is 0, both fine outputs stay 0, and the coarse outputs are unchanged.
- R6: New start, period, compare, fractional and enable values take effect only when they are captured, which happens in the cycle in which the counter equals the old shadowed period. Until then the old values govern every edge.
- R7: If the rise and fall compares of one channel match in the same cycle, the fall wins. The output goes (or stays) low, and the fine output carries the fall edge's code.
- R8: Compare and start values are signed. For example, a start of -8 (0xFFF8) with a rise at -3 (0xFFFD) and a fall at 3 gives a high time of six clocks.
- R9: Bits [10:0] of every fractional word have no effect on any output.
- R10: While reset (active low) is held, the counter reads 0 and both outputs and both fine codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fracEn | input | 1 | Fractional delay enable, captured at reload |
| initVal | input | 16 | Signed start value of the counter |
| periodVal | input | 16 | Signed last count before reload |
| riseA | input | 16 | Signed count at which A rises |
| fallA | input | 16 | Signed count at which A falls |
| riseB | input | 16 | Signed count at which B rises |
| fallB | input | 16 | Signed count at which B falls |
| fracRiseA | input | 16 | Fraction of A rise edge, code in [15:11] |
| fracFallA | input | 16 | Fraction of A fall edge, code in [15:11] |
| fracRiseB | input | 16 | Fraction of B rise edge, code in [15:11] |
| fracFallB | input | 16 | Fraction of B fall edge, code in [15:11] |
| pwmA | output | 1 | Coarse output A |
| pwmB | output | 1 | Coarse output B |
| fineA | output | 5 | Fine-delay code for the current A edge |
| fineB | output | 5 | Fine-delay code for the current B edge |
| count | output | 16 | Current signed counter value |

## Verification
Two events can land on the same count: a rise match and a fall match on one channel, and an edge match in the same cycle as the reload that swaps in new shadow values. The bench provokes the first by setting equal rise and fall compares, including inside a full sweep of every rise/fall pair over an eight-count period. It provokes the second by placing compares on the period value and by changing settings mid-period. A bench-side arithmetic model of the count sequence and of the shadow capture gives the expected outputs. The bench then checks that the fall wins and that the edge on the reload cycle still uses the old shadow values.

// File: rtl/fepPkg.sv
package fepPkg;
  localparam int CH_N = 2;          // independent outputs per submodule
  localparam int EDGE_N = 2 * CH_N; // rise and fall compare per output

  // strobes from the counter control to the output datapath
  typedef struct packed {
    logic            reload;
    logic [CH_N-1:0] setHit;
    logic [CH_N-1:0] clrHit;
  } strobeT;
endpackage

// File: rtl/fepCtrl.sv
module fepCtrl
  import fepPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [CNT_W-1:0] initIn,
  input  logic signed [CNT_W-1:0] periodIn,
  input  logic signed [CNT_W-1:0] cmpIn [EDGE_N],
  output logic signed [CNT_W-1:0] cnt,
  output strobeT                  stb
);

  logic signed [CNT_W-1:0] perSh;
  logic signed [CNT_W-1:0] cmpSh [EDGE_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      perSh <= '0;
      for (int e = 0; e < EDGE_N; e++) cmpSh[e] <= '0;
    end else if (stb.reload) begin
      cnt   <= initIn;
      perSh <= periodIn;
      for (int e = 0; e < EDGE_N; e++) cmpSh[e] <= cmpIn[e];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stb.reload = (cnt == perSh);
    for (int ch = 0; ch < CH_N; ch++) begin
      stb.setHit[ch] = (cnt == cmpSh[2*ch]);
      stb.clrHit[ch] = (cnt == cmpSh[2*ch+1]);
    end
  end

  // R1: a reload brings the start value seen at the reloading edge
  p_reload_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> cnt == $past(initIn));

  // R1: without reload the count advances by exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.reload |=> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/fepDatapath.sv
module fepDatapath
  import fepPkg::*;
#(
  parameter int REG_W  = 16,
  parameter int FRAC_W = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobeT                            stb,
  input  logic                              fracEnIn,
  input  logic [REG_W-1:0]                  fracIn [EDGE_N],
  output logic [CH_N-1:0]                   pwmOut,
  output logic [CH_N-1:0][FRAC_W-1:0]       fineOut
);

  localparam int FRAC_LSB = REG_W - FRAC_W;

  logic              enSh;
  logic [FRAC_W-1:0] fracSh [EDGE_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSh    <= 1'b0;
      pwmOut  <= '0;
      fineOut <= '0;
      for (int e = 0; e < EDGE_N; e++) fracSh[e] <= '0;
    end else begin
      for (int ch = 0; ch < CH_N; ch++) begin
        if (stb.clrHit[ch]) begin
          pwmOut[ch]  <= 1'b0;
          fineOut[ch] <= enSh ? fracSh[2*ch+1] : '0;
        end else if (stb.setHit[ch]) begin
          pwmOut[ch]  <= 1'b1;
          fineOut[ch] <= enSh ? fracSh[2*ch] : '0;
        end else begin
          fineOut[ch] <= '0;
        end
      end
      if (stb.reload) begin
        enSh <= fracEnIn;
        for (int e = 0; e < EDGE_N; e++) fracSh[e] <= fracIn[e][REG_W-1:FRAC_LSB];
      end
    end
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chk
    // R2 / R3: a lone rise match drives the output high next clock
    p_rise_high_r2_r3: assert property (@(posedge clk) disable iff (!rstN)
      stb.setHit[ch] && !stb.clrHit[ch] |=> pwmOut[ch]);
    // R7: any fall match, even with a rise match, leaves the output low
    p_fall_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      stb.clrHit[ch] |=> !pwmOut[ch]);
    // R2 / R3: no match, no change
    p_hold_r2_r3: assert property (@(posedge clk) disable iff (!rstN)
      !stb.setHit[ch] && !stb.clrHit[ch] |=> $stable(pwmOut[ch]));
    // R4: a fine code only accompanies an edge match
    p_fine_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
      !stb.setHit[ch] && !stb.clrHit[ch] |=> fineOut[ch] == '0);
    // R5: disabled fraction keeps the fine code at zero
    p_fine_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      !enSh |=> fineOut[ch] == '0);
  end

endmodule

// File: rtl/fracEdgePwm.sv
module fracEdgePwm
  import fepPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fracEn,
  input  logic signed [CNT_W-1:0] initVal,
  input  logic signed [CNT_W-1:0] periodVal,
  input  logic signed [CNT_W-1:0] riseA,
  input  logic signed [CNT_W-1:0] fallA,
  input  logic signed [CNT_W-1:0] riseB,
  input  logic signed [CNT_W-1:0] fallB,
  input  logic [CNT_W-1:0]        fracRiseA,
  input  logic [CNT_W-1:0]        fracFallA,
  input  logic [CNT_W-1:0]        fracRiseB,
  input  logic [CNT_W-1:0]        fracFallB,
  output logic                    pwmA,
  output logic                    pwmB,
  output logic [FRAC_W-1:0]       fineA,
  output logic [FRAC_W-1:0]       fineB,
  output logic signed [CNT_W-1:0] count
);

  strobeT                    stb;
  logic signed [CNT_W-1:0]   cmpArr  [EDGE_N];
  logic [CNT_W-1:0]          fracArr [EDGE_N];
  logic [CH_N-1:0]           pwmVec;
  logic [CH_N-1:0][FRAC_W-1:0] fineVec;

  assign cmpArr[0]  = riseA;
  assign cmpArr[1]  = fallA;
  assign cmpArr[2]  = riseB;
  assign cmpArr[3]  = fallB;
  assign fracArr[0] = fracRiseA;
  assign fracArr[1] = fracFallA;
  assign fracArr[2] = fracRiseB;
  assign fracArr[3] = fracFallB;

  fepCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .initIn   (initVal),
    .periodIn (periodVal),
    .cmpIn    (cmpArr),
    .cnt      (count),
    .stb      (stb)
  );

  fepDatapath #(.REG_W(CNT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .fracEnIn (fracEn),
    .fracIn   (fracArr),
    .pwmOut   (pwmVec),
    .fineOut  (fineVec)
  );

  assign pwmA  = pwmVec[0];
  assign pwmB  = pwmVec[1];
  assign fineA = fineVec[0];
  assign fineB = fineVec[1];

endmodule

// File: tb/sim_fracEdgePwm.sv
module sim_fracEdgePwm;
  localparam int W = 16;
  localparam int F = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, fracEn;
  logic signed [W-1:0] initV, perV, rA, fA, rB, fB;
  logic [W-1:0] frA, ffA, frB, ffB;
  logic pwmA, pwmB;
  logic [F-1:0] fineA, fineB;
  logic signed [W-1:0] count;

  fracEdgePwm u0 (
    .clk(clk), .rstN(rstN), .fracEn(fracEn),
    .initVal(initV), .periodVal(perV),
    .riseA(rA), .fallA(fA), .riseB(rB), .fallB(fB),
    .fracRiseA(frA), .fracFallA(ffA), .fracRiseB(frB), .fracFallB(ffB),
    .pwmA(pwmA), .pwmB(pwmB), .fineA(fineA), .fineB(fineB), .count(count)
  );

  int vecs = 0;
  int errs = 0;
  string scen = "reset";

  // bench model state
  logic signed [W-1:0] mCnt, mPer;
  logic signed [W-1:0] mCmp [4];
  logic [F-1:0]        mFrac [4];
  logic                mEn;
  logic [1:0]          mPwm;
  logic [F-1:0]        mFine [2];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s] at %0t: actual %0h expected %0h", req, scen, $time, act, exp);
    end
  endtask

  task automatic step();
    logic reload;
    logic usedEn;
    @(negedge clk);
    reload = (mCnt == mPer);
    usedEn = mEn;
    for (int ch = 0; ch < 2; ch++) begin
      if (mCnt == mCmp[2*ch+1]) begin
        mPwm[ch] = 1'b0;
        mFine[ch] = mEn ? mFrac[2*ch+1] : '0;
      end else if (mCnt == mCmp[2*ch]) begin
        mPwm[ch] = 1'b1;
        mFine[ch] = mEn ? mFrac[2*ch] : '0;
      end else begin
        mFine[ch] = '0;
      end
    end
    if (reload) begin
      mCnt = initV; mPer = perV;
      mCmp[0] = rA; mCmp[1] = fA; mCmp[2] = rB; mCmp[3] = fB;
      mFrac[0] = frA[15:11]; mFrac[1] = ffA[15:11];
      mFrac[2] = frB[15:11]; mFrac[3] = ffB[15:11];
      mEn = fracEn;
    end else begin
      mCnt = mCnt + 1'b1;
    end
    chk("R1", 32'(count), 32'(mCnt));
    chk("R2", 32'(pwmA), 32'(mPwm[0]));
    chk("R3", 32'(pwmB), 32'(mPwm[1]));
    chk(usedEn ? "R4" : "R5", 32'(fineA), 32'(mFine[0]));
    chk(usedEn ? "R4" : "R5", 32'(fineB), 32'(mFine[1]));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(int iv, int pv, int ra, int fa, int rb, int fb, logic en,
                     logic [15:0] a0, logic [15:0] a1, logic [15:0] b0, logic [15:0] b1);
    initV = W'(iv); perV = W'(pv);
    rA = W'(ra); fA = W'(fa); rB = W'(rb); fB = W'(fb);
    fracEn = en; frA = a0; ffA = a1; frB = b0; ffB = b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cfg(-8, 7, -3, 3, -3, 3, 1'b1, 16'h0, 16'hF000, 16'h0, 16'h0);
    mCnt = '0; mPer = '0; mEn = 1'b0; mPwm = '0;
    for (int e = 0; e < 4; e++) begin mCmp[e] = '0; mFrac[e] = '0; end
    mFine[0] = '0; mFine[1] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", 32'(count), 32'd0);
    chk("R10", 32'(pwmA), 32'd0);
    chk("R10", 32'(pwmB), 32'd0);
    chk("R10", 32'(fineA), 32'd0);
    chk("R10", 32'(fineB), 32'd0);
    rstN = 1'b1;

    // R8 / R4: signed example, only A fall carries a fraction (code 0x1E)
    scen = "R8 signed example with A fall fraction";
    run(48);

    // R5: fraction disabled
    scen = "R5 fraction disabled";
    fracEn = 1'b0;
    run(48);

    // R9: low bits junk; B rise code 0x11, B fall code 0
    scen = "R9 low fraction bits ignored";
    cfg(-8, 7, -3, 3, -5, 1, 1'b1, 16'h07FF, 16'hF7FF, 16'h8FFF, 16'h07FF);
    run(48);

    // R7: coinciding rise and fall, plus edges on the reload count
    scen = "R7 rise equals fall";
    cfg(0, 7, 2, 2, 7, 7, 1'b1, 16'h0800, 16'hF800, 16'h1000, 16'h2000);
    run(32);
    cfg(0, 7, 7, 4, 1, 7, 1'b1, 16'h1800, 16'h2800, 16'h3000, 16'hA000);
    run(32);

    // R6: settings changed mid-period, old shadows must govern
    scen = "R6 mid-period change";
    cfg(-4, 5, -2, 2, 0, 4, 1'b1, 16'h4000, 16'h8000, 16'hC000, 16'h0800);
    run(19);
    cfg(0, 9, 1, 8, 3, 5, 1'b0, 16'hF800, 16'hF800, 16'hF800, 16'hF800);
    run(3);
    cfg(-2, 3, -1, 2, 2, -2, 1'b1, 16'h5000, 16'h6000, 16'h7000, 16'h9000);
    run(40);

    // R2 / R3 / R4: full sweep of rise and fall over an eight-count period
    scen = "R2 R3 R4 sweep";
    for (int r = 0; r < 8; r++) begin
      for (int f = 0; f < 8; f++) begin
        cfg(0, 7, r, f, 7 - r, f ^ 3, 1'b1,
            16'((r * 4 + f) << 11), 16'((31 - r - f) << 11),
            16'((f * 4 + 1) << 11), 16'((r + 16) << 11));
        run(16);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule